// File: doc/BRIEF.md
# Operand and Effective Address Resolver

This combinational unit sits between the instruction decoder and the execution datapath of a processor core with variable operand sizes. It takes one decoded operand descriptor and reports where the operand lives. The operand can be a general-purpose register, with the byte lane to use, or a segment register. It can be the instruction's immediate. Otherwise it is a memory reference, and the unit supplies a computed offset and the segment to apply. The register file and the memory access itself are outside the block. The register file provides the current values of the index and base registers named by the descriptor.

The block serves two models, selected by one input. The narrow model has 16-bit addressing: the index is never scaled, index, base and displacement contribute only their low 16 bits, and the offset wraps at 16 bits. The wide model allows 32-bit register selection, uses the two extra segment registers, and shifts the index by the scale field. Each descriptor produces at most one kind of result. A descriptor that cannot be honoured raises an invalid flag, and then no result is produced.

Top module: `opnd_resolver`

## Requirements
- R1: For a general register operand (`src_kind`=1), codes 0 to 3 select registers 0 to 3. Byte size (`op_size`=0) gives lane 0 (low byte). Word size (`op_size`=1) gives lane 2 (16 bits).
- R2: At byte size, codes 4 to 7 select the high byte (lane 1) of registers 0 to 3. The register index is the code minus 4.
- R3: At word size, codes 4 to 7 select registers 4 to 7 with lane 2. At dword size (`op_size`=2) on the wide model, any code selects the same-numbered register with lane 3 (32 bits).
- R4: A dword register operand on the narrow model (`mode32`=0), or an operand of size code 3, raises `opnd_invalid` and performs no register read.
- R5: A segment register operand (`src_kind`=2) is legal only at word size. Codes 0 to 3 are legal on both models. Codes 4 and 5 are legal only on the wide model. Codes 6 and 7 are never legal. An illegal request raises `opnd_invalid` and performs no segment read.
- R6: The indirect form (`src_kind`=4) produces the offset (index << scale) + displacement + base. An absent index contributes zero, and so does an absent base.
- R7: On the narrow model the scale field has no effect on the offset.
- R8: The form without base (`src_kind`=5) omits the base term even when a base is present. The direct form (`src_kind`=6) uses the displacement alone.
- R9: On the narrow model the index, base and displacement contribute only their low 16 bits, and the offset is the low 16 bits of the sum with the upper bits zero.
- R10: An immediate operand (`src_kind`=3) asserts `imm_valid` and passes the immediate unchanged on `imm_data`.
- R11: The memory segment is the override code when `seg_ovr_valid` is set. Otherwise it is 2 (stack) when the indirect form has a present base with code 4 or 5, and 3 (data) in every other case.
- R12: At most one of `gpr_rd_en`, `sreg_rd_en`, `imm_valid`, `mem_req` is high. All four are low for `src_kind`=0, for the reserved `src_kind`=7, and whenever `opnd_invalid` is high. `src_kind`=7 always raises `opnd_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_kind | input | 3 | Operand kind: 0 none, 1 general register, 2 segment register, 3 immediate, 4 indirect, 5 indirect without base, 6 direct, 7 reserved |
| reg_code | input | 3 | Register code for register operands |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 dword, 3 reserved |
| mode32 | input | 1 | 1 selects the wide model, 0 the narrow model |
| idx_present | input | 1 | Index term exists |
| idx_val | input | 32 | Current value of the index register |
| base_present | input | 1 | Base term exists |
| base_code | input | 3 | Register code of the base register |
| base_val | input | 32 | Current value of the base register |
| scale | input | 2 | Left shift applied to the index on the wide model |
| disp | input | 32 | Displacement |
| imm | input | 32 | Instruction immediate |
| seg_ovr_valid | input | 1 | A segment override is present |
| seg_ovr_code | input | 3 | Segment override code |
| gpr_rd_en | output | 1 | General register read requested |
| gpr_rd_idx | output | 3 | General register index |
| gpr_lane | output | 2 | Lane: 0 low byte, 1 high byte, 2 16-bit, 3 32-bit |
| sreg_rd_en | output | 1 | Segment register read requested |
| sreg_rd_idx | output | 3 | Segment register index |
| imm_valid | output | 1 | Operand is the immediate |
| imm_data | output | 32 | Immediate value |
| mem_req | output | 1 | Operand is in memory |
| mem_seg | output | 3 | Segment for the memory access |
| mem_offset | output | 32 | Effective address offset |
| opnd_invalid | output | 1 | Descriptor cannot be honoured |

## Verification
The immediate assertions are evaluated on every input change. They cover the following: at most one result kind is active, and none is active when the descriptor is invalid; a high-byte lane only appears at byte size; a 32-bit lane only appears on the wide model; a granted segment read stays inside the model's legal set; the narrow-model offset never exceeds 16 bits. The actual arithmetic of the offset and the choice of default segment can only be shown by the bench's scenarios. These include scaling, missing index or base terms, an ignored base, 16-bit wrap, and truncation of register values. Alias decoding of the register codes is also shown only by the bench.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
    localparam int XLEN       = 32;
    localparam int NARROW_W   = 16;
    localparam int CODE_W     = 3;
    localparam int SCALE_W    = 2;
    localparam int NUM_RESULT = 4;

    typedef enum logic [2:0] {
        SK_NONE   = 3'd0,
        SK_GPR    = 3'd1,
        SK_SREG   = 3'd2,
        SK_IMM    = 3'd3,
        SK_IND    = 3'd4,
        SK_IND_NB = 3'd5,
        SK_DIRECT = 3'd6,
        SK_RSVD   = 3'd7
    } src_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } op_size_e;

    typedef enum logic [1:0] {
        LN_LO8 = 2'd0,
        LN_HI8 = 2'd1,
        LN_W16 = 2'd2,
        LN_D32 = 2'd3
    } lane_e;

    localparam logic [CODE_W-1:0] SEG_SS    = 3'd2;
    localparam logic [CODE_W-1:0] SEG_DS    = 3'd3;
    localparam logic [CODE_W-1:0] SEG_LAST  = 3'd5;
    localparam logic [CODE_W-1:0] GPR_SP    = 3'd4;
    localparam logic [CODE_W-1:0] GPR_BP    = 3'd5;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] idx;
        lane_e             lane;
        logic              bad;
    } gpr_sel_t;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] idx;
        logic              bad;
    } seg_sel_t;

    // Keep the full value on the wide model, only the low half on the narrow one.
    function automatic logic [XLEN-1:0] fit_model(input logic [XLEN-1:0] v, input logic wide);
        logic [XLEN-1:0] r;
        r = v;
        if (!wide) r = {{(XLEN-NARROW_W){1'b0}}, v[NARROW_W-1:0]};
        return r;
    endfunction

    function automatic logic is_stack_base(input logic [CODE_W-1:0] code);
        return (code == GPR_SP) || (code == GPR_BP);
    endfunction

    function automatic logic is_mem_kind(input src_kind_e k);
        return (k == SK_IND) || (k == SK_IND_NB) || (k == SK_DIRECT);
    endfunction
endpackage

// File: rtl/opnd_gpr_decode.sv
module opnd_gpr_decode
    import opnd_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  op_size_e          size,
    input  logic              wide,
    output gpr_sel_t          sel
);
    always_comb begin
        sel = '{en: 1'b0, idx: '0, lane: LN_LO8, bad: 1'b0};
        unique case (size)
            SZ_BYTE: begin
                sel.en   = 1'b1;
                sel.idx  = {1'b0, code[CODE_W-2:0]};
                sel.lane = code[CODE_W-1] ? LN_HI8 : LN_LO8;
            end
            SZ_WORD: begin
                sel.en   = 1'b1;
                sel.idx  = code;
                sel.lane = LN_W16;
            end
            SZ_DWORD: begin
                if (wide) begin
                    sel.en   = 1'b1;
                    sel.idx  = code;
                    sel.lane = LN_D32;
                end else begin
                    sel.bad  = 1'b1;
                end
            end
            default: sel.bad = 1'b1;
        endcase
    end

    always_comb begin
        p_hi_lane_byte_r2: assert (!(sel.en && sel.lane == LN_HI8) || size == SZ_BYTE)
            else $error("high-byte lane at non-byte size");
        p_byte_idx_low_r1: assert (!(sel.en && size == SZ_BYTE) || !sel.idx[CODE_W-1])
            else $error("byte select outside registers 0..3");
        p_d32_needs_wide_r4: assert (!(sel.en && sel.lane == LN_D32) || wide)
            else $error("32-bit lane on narrow model");
        p_en_xor_bad_r4: assert (!(sel.en && sel.bad))
            else $error("register select both granted and refused");
    end
endmodule

// File: rtl/opnd_sreg_decode.sv
module opnd_sreg_decode
    import opnd_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  op_size_e          size,
    input  logic              wide,
    output seg_sel_t          sel
);
    logic legal_code;

    always_comb begin
        legal_code = (code <= SEG_DS) || (wide && code <= SEG_LAST);
        sel.idx    = code;
        sel.en     = (size == SZ_WORD) && legal_code;
        sel.bad    = !sel.en;
    end

    always_comb begin
        p_seg_word_only_r5: assert (!sel.en || size == SZ_WORD)
            else $error("segment read at non-word size");
        p_seg_model_gate_r5: assert (!sel.en || wide || sel.idx <= SEG_DS)
            else $error("extra segment granted on narrow model");
    end
endmodule

// File: rtl/opnd_ea_calc.sv
module opnd_ea_calc
    import opnd_pkg::*;
#(
    parameter int AW = XLEN
) (
    input  src_kind_e           kind,
    input  logic                wide,
    input  logic                idx_present,
    input  logic [AW-1:0]       idx_val,
    input  logic                base_present,
    input  logic [AW-1:0]       base_val,
    input  logic [SCALE_W-1:0]  scale,
    input  logic [AW-1:0]       disp,
    output logic [AW-1:0]       offset
);
    localparam int SHIFTS = 1 << SCALE_W;

    logic [AW-1:0] idx_fit, base_fit, disp_fit;
    logic [AW-1:0] shifted [SHIFTS];
    logic [AW-1:0] idx_term, base_term, sum;
    logic          use_idx, use_base;

    always_comb begin
        idx_fit  = fit_model(idx_val, wide);
        base_fit = fit_model(base_val, wide);
        disp_fit = fit_model(disp, wide);
    end

    for (genvar s = 0; s < SHIFTS; s++) begin : g_scale
        assign shifted[s] = idx_fit << s;
    end

    always_comb begin
        use_idx   = idx_present && (kind == SK_IND || kind == SK_IND_NB);
        use_base  = base_present && (kind == SK_IND);
        idx_term  = '0;
        if (use_idx) idx_term = wide ? shifted[scale] : idx_fit;
        base_term = use_base ? base_fit : '0;
        sum       = idx_term + base_term + disp_fit;
        offset    = fit_model(sum, wide);
    end

    always_comb begin
        p_wrap16_r9: assert (wide || offset[AW-1:NARROW_W] == '0)
            else $error("narrow offset exceeds 16 bits");
    end
endmodule

// File: rtl/opnd_seg_pick.sv
module opnd_seg_pick
    import opnd_pkg::*;
(
    input  src_kind_e          kind,
    input  logic               ovr_valid,
    input  logic [CODE_W-1:0]  ovr_code,
    input  logic               base_present,
    input  logic [CODE_W-1:0]  base_code,
    output logic [CODE_W-1:0]  seg
);
    logic stack_default;

    always_comb begin
        stack_default = (kind == SK_IND) && base_present && is_stack_base(base_code);
        if (ovr_valid) seg = ovr_code;
        else           seg = stack_default ? SEG_SS : SEG_DS;
    end

    always_comb begin
        p_override_wins_r11: assert (!ovr_valid || seg == ovr_code)
            else $error("override not applied");
        p_default_pair_r11: assert (ovr_valid || seg == SEG_SS || seg == SEG_DS)
            else $error("default segment outside stack/data");
    end
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
    import opnd_pkg::*;
(
    input  logic [2:0]  src_kind,
    input  logic [2:0]  reg_code,
    input  logic [1:0]  op_size,
    input  logic        mode32,
    input  logic        idx_present,
    input  logic [31:0] idx_val,
    input  logic        base_present,
    input  logic [2:0]  base_code,
    input  logic [31:0] base_val,
    input  logic [1:0]  scale,
    input  logic [31:0] disp,
    input  logic [31:0] imm,
    input  logic        seg_ovr_valid,
    input  logic [2:0]  seg_ovr_code,
    output logic        gpr_rd_en,
    output logic [2:0]  gpr_rd_idx,
    output logic [1:0]  gpr_lane,
    output logic        sreg_rd_en,
    output logic [2:0]  sreg_rd_idx,
    output logic        imm_valid,
    output logic [31:0] imm_data,
    output logic        mem_req,
    output logic [2:0]  mem_seg,
    output logic [31:0] mem_offset,
    output logic        opnd_invalid
);
    src_kind_e       kind;
    op_size_e        size;
    gpr_sel_t        gsel;
    seg_sel_t        ssel;
    logic [XLEN-1:0] ea;
    logic [CODE_W-1:0] seg;

    assign kind = src_kind_e'(src_kind);
    assign size = op_size_e'(op_size);

    opnd_gpr_decode u_gpr (
        .code (reg_code),
        .size (size),
        .wide (mode32),
        .sel  (gsel)
    );

    opnd_sreg_decode u_sreg (
        .code (reg_code),
        .size (size),
        .wide (mode32),
        .sel  (ssel)
    );

    opnd_ea_calc #(.AW(XLEN)) u_ea (
        .kind         (kind),
        .wide         (mode32),
        .idx_present  (idx_present),
        .idx_val      (idx_val),
        .base_present (base_present),
        .base_val     (base_val),
        .scale        (scale),
        .disp         (disp),
        .offset       (ea)
    );

    opnd_seg_pick u_seg (
        .kind         (kind),
        .ovr_valid    (seg_ovr_valid),
        .ovr_code     (seg_ovr_code),
        .base_present (base_present),
        .base_code    (base_code),
        .seg          (seg)
    );

    always_comb begin
        opnd_invalid = (kind == SK_RSVD)
                    || (kind == SK_GPR  && gsel.bad)
                    || (kind == SK_SREG && ssel.bad);
        gpr_rd_en    = (kind == SK_GPR)  && gsel.en;
        gpr_rd_idx   = gsel.idx;
        gpr_lane     = gsel.lane;
        sreg_rd_en   = (kind == SK_SREG) && ssel.en;
        sreg_rd_idx  = ssel.idx;
        imm_valid    = (kind == SK_IMM);
        imm_data     = imm;
        mem_req      = is_mem_kind(kind);
        mem_seg      = seg;
        mem_offset   = ea;
    end

    always_comb begin
        p_one_result_r12: assert ($onehot0({gpr_rd_en, sreg_rd_en, imm_valid, mem_req}))
            else $error("more than one result kind active");
        p_invalid_quiet_r12: assert (!opnd_invalid ||
                                     !(gpr_rd_en || sreg_rd_en || imm_valid || mem_req))
            else $error("result produced for invalid descriptor");
        p_seg_grant_range_r5: assert (!sreg_rd_en || sreg_rd_idx <= SEG_LAST)
            else $error("segment index out of range");
    end
endmodule

// File: tb/tb_opnd_resolver.sv
module tb_opnd_resolver;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [2:0]  src_kind, reg_code, base_code, seg_ovr_code;
    logic [1:0]  op_size, scale;
    logic        mode32, idx_present, base_present, seg_ovr_valid;
    logic [31:0] idx_val, base_val, disp, imm;
    logic        gpr_rd_en, sreg_rd_en, imm_valid, mem_req, opnd_invalid;
    logic [2:0]  gpr_rd_idx, sreg_rd_idx, mem_seg;
    logic [1:0]  gpr_lane;
    logic [31:0] imm_data, mem_offset;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    opnd_resolver dut (.*);

    typedef struct packed {
        logic [2:0]  kind;
        logic        m32;
        logic        ip;
        logic [31:0] iv;
        logic        bp;
        logic [2:0]  bc;
        logic [31:0] bv;
        logic [1:0]  sc;
        logic [31:0] dp;
        logic        ov;
        logic [2:0]  oc;
        logic [31:0] eoff;
        logic [2:0]  eseg;
    } av_t;

    localparam int NAV = 9;
    localparam av_t AV [NAV] = '{
        // R6 R11: scaled index + disp + base, data default
        '{3'd4, 1'b1, 1'b1, 32'h10, 1'b1, 3'd3, 32'h1000, 2'd2, 32'h20, 1'b0, 3'd0, 32'h1060, 3'd3},
        // R6 R11: no index, BP base -> stack
        '{3'd4, 1'b1, 1'b0, 32'h77, 1'b1, 3'd5, 32'h2000, 2'd1, 32'hFFFFFFF0, 1'b0, 3'd0, 32'h1FF0, 3'd2},
        // R7: narrow model ignores scale, SP base -> stack
        '{3'd4, 1'b0, 1'b1, 32'h3, 1'b1, 3'd4, 32'h100, 2'd3, 32'h4, 1'b0, 3'd0, 32'h107, 3'd2},
        // R9: narrow wrap
        '{3'd4, 1'b0, 1'b1, 32'hFFFF, 1'b1, 3'd6, 32'h2, 2'd0, 32'h0, 1'b0, 3'd0, 32'h1, 3'd3},
        // R8 R11: no-base form ignores base, data default
        '{3'd5, 1'b1, 1'b1, 32'h5, 1'b1, 3'd5, 32'h9999, 2'd1, 32'h100, 1'b0, 3'd0, 32'h10A, 3'd3},
        // R8: direct uses displacement only
        '{3'd6, 1'b1, 1'b1, 32'h7, 1'b1, 3'd3, 32'h55, 2'd2, 32'h12345678, 1'b0, 3'd0, 32'h12345678, 3'd3},
        // R11: override beats stack default
        '{3'd4, 1'b1, 1'b0, 32'h0, 1'b1, 3'd5, 32'h10, 2'd0, 32'h0, 1'b1, 3'd0, 32'h10, 3'd0},
        // R11: override on direct form
        '{3'd6, 1'b1, 1'b0, 32'h0, 1'b0, 3'd0, 32'h0, 2'd0, 32'h44, 1'b1, 3'd5, 32'h44, 3'd5},
        // R9: narrow model truncates register values and displacement
        '{3'd4, 1'b0, 1'b1, 32'h00120005, 1'b1, 3'd3, 32'h00AB0010, 2'd0, 32'h00010000, 1'b0, 3'd0, 32'h15, 3'd3}
    };

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic clear_inputs();
        src_kind = 3'd0; reg_code = 3'd0; op_size = 2'd0; mode32 = 1'b1;
        idx_present = 1'b0; idx_val = '0; base_present = 1'b0; base_code = 3'd0;
        base_val = '0; scale = 2'd0; disp = '0; imm = '0;
        seg_ovr_valid = 1'b0; seg_ovr_code = 3'd0;
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic gpr_case(input string req, input logic [2:0] code, input logic [1:0] sz,
                            input logic m32, input logic eok, input logic [2:0] eidx,
                            input logic [1:0] elane);
        clear_inputs();
        src_kind = 3'd1; reg_code = code; op_size = sz; mode32 = m32;
        settle();
        chk(req, "gpr_rd_en", 32'(gpr_rd_en), 32'(eok));
        chk(req, "opnd_invalid", 32'(opnd_invalid), 32'(!eok));
        if (eok) begin
            chk(req, "gpr_rd_idx", 32'(gpr_rd_idx), 32'(eidx));
            chk(req, "gpr_lane", 32'(gpr_lane), 32'(elane));
        end
    endtask

    task automatic seg_case(input string req, input logic [2:0] code, input logic [1:0] sz,
                            input logic m32, input logic eok);
        clear_inputs();
        src_kind = 3'd2; reg_code = code; op_size = sz; mode32 = m32;
        settle();
        chk(req, "sreg_rd_en", 32'(sreg_rd_en), 32'(eok));
        chk(req, "opnd_invalid", 32'(opnd_invalid), 32'(!eok));
        if (eok) chk(req, "sreg_rd_idx", 32'(sreg_rd_idx), 32'(code));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        settle();
        // R12: idle descriptor produces nothing
        chk("R12", "idle results", 32'({gpr_rd_en, sreg_rd_en, imm_valid, mem_req, opnd_invalid}), 32'h0);

        for (int i = 0; i < NAV; i++) begin
            clear_inputs();
            src_kind = AV[i].kind; mode32 = AV[i].m32; idx_present = AV[i].ip;
            idx_val = AV[i].iv; base_present = AV[i].bp; base_code = AV[i].bc;
            base_val = AV[i].bv; scale = AV[i].sc; disp = AV[i].dp;
            seg_ovr_valid = AV[i].ov; seg_ovr_code = AV[i].oc;
            settle();
            chk("R6/R8/R9 mem", "mem_req", 32'(mem_req), 32'h1);
            chk("R6/R7/R8/R9 address", "mem_offset", mem_offset, AV[i].eoff);
            chk("R11 segment", "mem_seg", 32'(mem_seg), 32'(AV[i].eseg));
        end

        gpr_case("R1", 3'd2, 2'd0, 1'b1, 1'b1, 3'd2, 2'd0);
        gpr_case("R1", 3'd1, 2'd1, 1'b0, 1'b1, 3'd1, 2'd2);
        gpr_case("R2", 3'd6, 2'd0, 1'b0, 1'b1, 3'd2, 2'd1);
        gpr_case("R2", 3'd4, 2'd0, 1'b1, 1'b1, 3'd0, 2'd1);
        gpr_case("R3", 3'd6, 2'd1, 1'b1, 1'b1, 3'd6, 2'd2);
        gpr_case("R3", 3'd5, 2'd2, 1'b1, 1'b1, 3'd5, 2'd3);
        gpr_case("R4", 3'd5, 2'd2, 1'b0, 1'b0, 3'd0, 2'd0);
        gpr_case("R4", 3'd1, 2'd3, 1'b1, 1'b0, 3'd0, 2'd0);

        seg_case("R5", 3'd3, 2'd1, 1'b0, 1'b1);
        seg_case("R5", 3'd3, 2'd0, 1'b1, 1'b0);
        seg_case("R5", 3'd4, 2'd1, 1'b0, 1'b0);
        seg_case("R5", 3'd5, 2'd1, 1'b1, 1'b1);
        seg_case("R5", 3'd6, 2'd1, 1'b1, 1'b0);
        seg_case("R5", 3'd1, 2'd2, 1'b1, 1'b0);

        // R10: immediate passthrough
        clear_inputs();
        src_kind = 3'd3; imm = 32'hDEADBEEF; op_size = 2'd0;
        settle();
        chk("R10", "imm_valid", 32'(imm_valid), 32'h1);
        chk("R10", "imm_data", imm_data, 32'hDEADBEEF);
        chk("R12", "only imm", 32'({gpr_rd_en, sreg_rd_en, mem_req}), 32'h0);

        // R12: reserved kind is invalid and quiet
        clear_inputs();
        src_kind = 3'd7; op_size = 2'd1;
        settle();
        chk("R12", "opnd_invalid", 32'(opnd_invalid), 32'h1);
        chk("R12", "reserved results", 32'({gpr_rd_en, sreg_rd_en, imm_valid, mem_req}), 32'h0);

        // R12: register kind never raises a memory request
        clear_inputs();
        src_kind = 3'd1; op_size = 2'd1; base_present = 1'b1; disp = 32'h40;
        settle();
        chk("R12", "mem_req on register", 32'(mem_req), 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule